// File: doc/BRIEF.md
# LCD panel timing generator

This block turns a set of static timing values into the sequencing signals an LCD panel needs. A pixel position counter and a line counter walk the frame. From their values the block builds a line pulse, a frame pulse whose edges may sit part way through a line, a shift clock enable, and a data-enable strobe. While data-enable is high, incoming pixel data is passed to the output; otherwise the output is zero. When the high-reflectivity TFT mode is selected, four extra control strobes are produced. Two are windows with their own start and stop positions. One toggles once per line at a set position. One marks the first display pixel.

The panel mode chooses the shift clock gating. Colour passive panels and TFT panels get a shift clock only inside the horizontal display window. Monochrome passive panels get a free-running shift clock unless the gating mask is set. All timing values, the mode and the mask are captured at the start of each frame, so a frame never mixes old and new settings. Every output is a register and shows the decode of the counter position from the cycle before.

Top module: `lcd_panel_timing`

## Requirements
- R1: The pixel position runs 0 to `h_total`-1 and then returns to 0. `line_pulse` is high for positions `h_sync_start` through `h_sync_start`+`h_sync_len`-1 of every line. Each output appears one clock after the counter position it decodes.
- R2: The line count runs 0 to `v_total`-1. `frame_pulse` rises at line `v_sync_start`, position `h_sync_start`+`fsync_on_ofs`. It falls at line `v_sync_start`+`v_sync_len`, position `h_sync_start`+`fsync_off_ofs`. Both lines and both positions must lie inside the frame.
- R3: `data_en` is high for positions `h_act_start` through `h_act_start`+`h_act_len`-1 on lines `v_act_start` through `v_act_start`+`v_act_len`-1. `pix_out` is the `pix_in` value captured in the same cycle while `data_en` is high, and zero otherwise.
- R4: In colour passive mode (`mode` = 2'b01) and in TFT mode (`mode[1]` = 1), `shift_en` equals the horizontal display window on every line, including lines outside the vertical display range.
- R5: In monochrome passive mode (`mode` = 2'b00), `shift_en` stays high at all times when `mono_shift_mask` = 0. It follows the horizontal display window when `mono_shift_mask` = 1.
- R6: In TFT mode, `tft_ctl[0]` is high for positions `ctl0_start` through `ctl0_stop`-1. `tft_ctl[1]` is high for positions `ctl1_start` through `ctl1_stop`-1. A stop value equal to the start value gives no pulse.
- R7: In TFT mode, `tft_ctl[2]` inverts once per line, taking effect on the output one clock after position `ctl2_delay`.
- R8: In TFT mode, `tft_ctl[3]` is a one-clock strobe for position `h_act_start` of every line.
- R9: In either passive mode, all four `tft_ctl` bits stay low. The toggle state behind `tft_ctl[2]` is cleared.
- R10: While the synchronous reset `rst` is high, every output is low and both counters return to zero. The first clock after release decodes position 0 of line 0.
- R11: Timing values, `mode` and `mono_shift_mask` are sampled during reset and in the last cycle of each frame. A change made part way through a frame has no effect until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 monochrome passive, 01 colour passive, 1x TFT |
| mono_shift_mask | input | 1 | Gates the monochrome shift clock outside the display window |
| h_total | input | HW | Pixel clocks per line |
| h_act_start | input | HW | First display pixel position |
| h_act_len | input | HW | Display pixels per line |
| h_sync_start | input | HW | Line pulse start position |
| h_sync_len | input | HW | Line pulse width |
| v_total | input | VW | Lines per frame |
| v_act_start | input | VW | First display line |
| v_act_len | input | VW | Display lines per frame |
| v_sync_start | input | VW | Line on which the frame pulse rises |
| v_sync_len | input | VW | Lines from frame pulse rise line to fall line |
| fsync_on_ofs | input | HW | Frame pulse rise offset after the line pulse start |
| fsync_off_ofs | input | HW | Frame pulse fall offset after the line pulse start |
| ctl0_start | input | HW | First position of control strobe 0 |
| ctl0_stop | input | HW | Position that ends control strobe 0 |
| ctl1_start | input | HW | First position of control strobe 1 |
| ctl1_stop | input | HW | Position that ends control strobe 1 |
| ctl2_delay | input | HW | Position at which control strobe 2 inverts |
| pix_in | input | DW | Pixel data from the fetch path |
| line_pulse | output | 1 | Horizontal sync pulse |
| frame_pulse | output | 1 | Vertical sync pulse |
| shift_en | output | 1 | Shift clock enable |
| data_en | output | 1 | Display data valid |
| pix_out | output | DW | Gated pixel data |
| tft_ctl | output | 4 | TFT control strobes |

## Verification
The bench first runs the monochrome mode with the mask cleared and then set. A design that gated the free-running clock would drop `shift_en` in the blanking interval. A design that ignored the mask would leave `shift_en` running. The second geometry puts the display window flush against the end of the line and places the line pulse and both frame pulse edges in its last two positions. It also gives control strobe 1 an empty window. An off-by-one in a span compare, or a sum that wraps, would show as a stray or missing pulse there. The geometry change is applied part way through a frame to catch a design that loads settings at once. A reset in the middle of TFT operation checks that the toggling strobe and the frame pulse do not keep stale state.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

   localparam logic [1:0] LCDT_MODE_MONO  = 2'b00;
   localparam logic [1:0] LCDT_MODE_COLOR = 2'b01;

   function automatic logic in_span(input int unsigned p, input int unsigned s,
                                    input int unsigned n);
      return (p >= s) && (p < s + n);
   endfunction

   function automatic logic is_tft(input logic [1:0] m);
      return m[1];
   endfunction

endpackage

// File: rtl/lcdt_timebase.sv
module lcdt_timebase #(
   parameter int HW = 11,
   parameter int VW = 10
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [HW-1:0] ht,
   input  logic [VW-1:0] vt,
   output logic [HW-1:0] hc,
   output logic [VW-1:0] vc,
   output logic          frame_last
);
   logic line_last, vlast;

   assign line_last  = ((HW+1)'(hc) + (HW+1)'(1)) >= (HW+1)'(ht);
   assign vlast      = ((VW+1)'(vc) + (VW+1)'(1)) >= (VW+1)'(vt);
   assign frame_last = line_last & vlast;

   always_ff @(posedge clk) begin
      if (rst) begin
         hc <= '0;
         vc <= '0;
      end else if (line_last) begin
         hc <= '0;
         vc <= vlast ? '0 : vc + 1'b1;
      end else begin
         hc <= hc + 1'b1;
      end
   end

   p_hc_wrap_r1: assert property (@(posedge clk) disable iff (rst)
      line_last |=> (hc == '0));
   p_hc_step_r1: assert property (@(posedge clk) disable iff (rst)
      !line_last |=> (hc == $past(hc) + 1'b1));
   p_vc_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !line_last |=> $stable(vc));
endmodule

// File: rtl/lcdt_window.sv
module lcdt_window #(
   parameter int W         = 11,
   parameter bit STOP_FORM = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] pos,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         q
);
   logic hit;

   generate
      if (STOP_FORM) begin : g_stop
         assign hit = (pos >= a) && (pos < b);
      end else begin : g_len
         assign hit = ((W+1)'(pos) >= (W+1)'(a)) &&
                      ((W+1)'(pos) < ((W+1)'(a) + (W+1)'(b)));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= en & hit;
   end

   p_win_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      !en |=> !q);
endmodule

// File: rtl/lcd_panel_timing.sv
module lcd_panel_timing
   import lcdt_pkg::*;
#(
   parameter int HW = 11,
   parameter int VW = 10,
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [1:0]    mode,
   input  logic          mono_shift_mask,
   input  logic [HW-1:0] h_total,
   input  logic [HW-1:0] h_act_start,
   input  logic [HW-1:0] h_act_len,
   input  logic [HW-1:0] h_sync_start,
   input  logic [HW-1:0] h_sync_len,
   input  logic [VW-1:0] v_total,
   input  logic [VW-1:0] v_act_start,
   input  logic [VW-1:0] v_act_len,
   input  logic [VW-1:0] v_sync_start,
   input  logic [VW-1:0] v_sync_len,
   input  logic [HW-1:0] fsync_on_ofs,
   input  logic [HW-1:0] fsync_off_ofs,
   input  logic [HW-1:0] ctl0_start,
   input  logic [HW-1:0] ctl0_stop,
   input  logic [HW-1:0] ctl1_start,
   input  logic [HW-1:0] ctl1_stop,
   input  logic [HW-1:0] ctl2_delay,
   input  logic [DW-1:0] pix_in,
   output logic          line_pulse,
   output logic          frame_pulse,
   output logic          shift_en,
   output logic          data_en,
   output logic [DW-1:0] pix_out,
   output logic [3:0]    tft_ctl
);
   localparam int NWIN = 2;

   generate
      if (HW < 2 || HW > 16) begin : g_bad_hw
         $error("lcd_panel_timing: HW out of range");
      end
      if (VW < 2 || VW > 16) begin : g_bad_vw
         $error("lcd_panel_timing: VW out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("lcd_panel_timing: DW must be positive");
      end
   endgenerate

   // frame-synchronous copy of every setting
   logic [1:0]    mode_q;
   logic          mask_q;
   logic [HW-1:0] ht_q, hs_q, hl_q, hps_q, hpw_q, fon_q, foff_q, c2d_q;
   logic [VW-1:0] vt_q, vs_q, vl_q, vps_q, vpw_q;
   logic [HW-1:0] cwin_a_q [NWIN];
   logic [HW-1:0] cwin_b_q [NWIN];

   logic [HW-1:0] hc;
   logic [VW-1:0] vc;
   logic          frame_last, load;

   assign load = rst | frame_last;

   always_ff @(posedge clk) begin
      if (load) begin
         mode_q      <= mode;
         mask_q      <= mono_shift_mask;
         ht_q        <= h_total;
         hs_q        <= h_act_start;
         hl_q        <= h_act_len;
         hps_q       <= h_sync_start;
         hpw_q       <= h_sync_len;
         vt_q        <= v_total;
         vs_q        <= v_act_start;
         vl_q        <= v_act_len;
         vps_q       <= v_sync_start;
         vpw_q       <= v_sync_len;
         fon_q       <= fsync_on_ofs;
         foff_q      <= fsync_off_ofs;
         c2d_q       <= ctl2_delay;
         cwin_a_q[0] <= ctl0_start;
         cwin_b_q[0] <= ctl0_stop;
         cwin_a_q[1] <= ctl1_start;
         cwin_b_q[1] <= ctl1_stop;
      end
   end

   lcdt_timebase #(.HW(HW), .VW(VW)) i_tb (
      .clk(clk), .rst(rst), .ht(ht_q), .vt(vt_q),
      .hc(hc), .vc(vc), .frame_last(frame_last)
   );

   lcdt_window #(.W(HW), .STOP_FORM(1'b0)) i_hsync (
      .clk(clk), .rst(rst), .en(1'b1), .pos(hc),
      .a(hps_q), .b(hpw_q), .q(line_pulse)
   );

   logic tft;
   assign tft = is_tft(mode_q);

   genvar gi;
   generate
      for (gi = 0; gi < NWIN; gi++) begin : g_cwin
         lcdt_window #(.W(HW), .STOP_FORM(1'b1)) i_cwin (
            .clk(clk), .rst(rst), .en(tft), .pos(hc),
            .a(cwin_a_q[gi]), .b(cwin_b_q[gi]), .q(tft_ctl[gi])
         );
      end
   endgenerate

   // display windows and frame pulse edges
   logic hdisp, vdisp, fp_set, fp_clr, shift_d;
   logic [HW:0] fp_on_pos, fp_off_pos;
   logic [VW:0] fp_off_line;

   assign hdisp       = in_span(32'(hc), 32'(hs_q), 32'(hl_q));
   assign vdisp       = in_span(32'(vc), 32'(vs_q), 32'(vl_q));
   assign fp_on_pos   = (HW+1)'(hps_q) + (HW+1)'(fon_q);
   assign fp_off_pos  = (HW+1)'(hps_q) + (HW+1)'(foff_q);
   assign fp_off_line = (VW+1)'(vps_q) + (VW+1)'(vpw_q);
   assign fp_set      = (vc == vps_q) && ((HW+1)'(hc) == fp_on_pos);
   assign fp_clr      = ((VW+1)'(vc) == fp_off_line) && ((HW+1)'(hc) == fp_off_pos);

   always_comb begin
      if (mode_q == LCDT_MODE_MONO) shift_d = mask_q ? hdisp : 1'b1;
      else                          shift_d = hdisp;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         frame_pulse <= 1'b0;
         shift_en    <= 1'b0;
         data_en     <= 1'b0;
         pix_out     <= '0;
         tft_ctl[2]  <= 1'b0;
         tft_ctl[3]  <= 1'b0;
      end else begin
         if (fp_set)      frame_pulse <= 1'b1;
         else if (fp_clr) frame_pulse <= 1'b0;
         shift_en   <= shift_d;
         data_en    <= hdisp & vdisp;
         pix_out    <= (hdisp & vdisp) ? pix_in : '0;
         tft_ctl[2] <= tft & (tft_ctl[2] ^ (hc == c2d_q));
         tft_ctl[3] <= tft & (hc == hs_q);
      end
   end

   p_pix_gate_r3: assert property (@(posedge clk) disable iff (rst)
      !data_en |-> (pix_out == '0));
   p_de_shift_r4: assert property (@(posedge clk) disable iff (rst)
      data_en |-> shift_en);
   p_mono_free_r5: assert property (@(posedge clk) disable iff (rst)
      (mode_q == LCDT_MODE_MONO && !mask_q) |=> shift_en);
   p_ctl_idle_r9: assert property (@(posedge clk) disable iff (rst)
      !tft |=> (tft_ctl == 4'b0000));
   p_ctl3_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      (tft_ctl[3] && ht_q > 1 && !frame_last) |=> !tft_ctl[3]);
   p_reset_quiet_r10: assert property (@(posedge clk)
      rst |=> (tft_ctl == 4'b0000 && !frame_pulse && !data_en));
endmodule

// File: tb/test_lcd_panel_timing.sv
module test_lcd_panel_timing;
   localparam int HW = 11;
   localparam int VW = 10;
   localparam int DW = 24;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [1:0] mode = 2'b00;
   logic mono_shift_mask = 1'b0;
   logic [HW-1:0] h_total, h_act_start, h_act_len, h_sync_start, h_sync_len;
   logic [VW-1:0] v_total, v_act_start, v_act_len, v_sync_start, v_sync_len;
   logic [HW-1:0] fsync_on_ofs, fsync_off_ofs, ctl0_start, ctl0_stop;
   logic [HW-1:0] ctl1_start, ctl1_stop, ctl2_delay;
   logic [DW-1:0] pix_in = '0;
   logic line_pulse, frame_pulse, shift_en, data_en;
   logic [DW-1:0] pix_out;
   logic [3:0] tft_ctl;

   always #2 clk = ~clk;

   lcd_panel_timing #(.HW(HW), .VW(VW), .DW(DW)) i_lcd_panel_timing (
      .clk(clk), .rst(rst), .mode(mode), .mono_shift_mask(mono_shift_mask),
      .h_total(h_total), .h_act_start(h_act_start), .h_act_len(h_act_len),
      .h_sync_start(h_sync_start), .h_sync_len(h_sync_len),
      .v_total(v_total), .v_act_start(v_act_start), .v_act_len(v_act_len),
      .v_sync_start(v_sync_start), .v_sync_len(v_sync_len),
      .fsync_on_ofs(fsync_on_ofs), .fsync_off_ofs(fsync_off_ofs),
      .ctl0_start(ctl0_start), .ctl0_stop(ctl0_stop),
      .ctl1_start(ctl1_start), .ctl1_stop(ctl1_stop), .ctl2_delay(ctl2_delay),
      .pix_in(pix_in), .line_pulse(line_pulse), .frame_pulse(frame_pulse),
      .shift_en(shift_en), .data_en(data_en), .pix_out(pix_out), .tft_ctl(tft_ctl)
   );

   int tests = 0;
   int fails = 0;
   bit checking = 1'b0;
   bit pend = 1'b0;

   // reference model state
   int m_hc, m_vc, s_mode, s_mask;
   int s_ht, s_hs, s_hl, s_hps, s_hpw, s_vt, s_vs, s_vl, s_vps, s_vpw;
   int s_fon, s_foff, s_c0a, s_c0b, s_c1a, s_c1b, s_c2d;
   bit e_lp, e_fp, e_sh, e_de, e_c2;
   bit [3:0] e_ctl;
   logic [DW-1:0] e_pix;
   bit was_rst;

   task automatic load_shadow();
      s_mode = int'(mode); s_mask = int'(mono_shift_mask);
      s_ht = int'(h_total); s_hs = int'(h_act_start); s_hl = int'(h_act_len);
      s_hps = int'(h_sync_start); s_hpw = int'(h_sync_len);
      s_vt = int'(v_total); s_vs = int'(v_act_start); s_vl = int'(v_act_len);
      s_vps = int'(v_sync_start); s_vpw = int'(v_sync_len);
      s_fon = int'(fsync_on_ofs); s_foff = int'(fsync_off_ofs);
      s_c0a = int'(ctl0_start); s_c0b = int'(ctl0_stop);
      s_c1a = int'(ctl1_start); s_c1b = int'(ctl1_stop); s_c2d = int'(ctl2_delay);
      pend = 1'b0;
   endtask

   always @(posedge clk) begin
      was_rst = rst;
      if (rst) begin
         m_hc = 0; m_vc = 0;
         e_lp = 0; e_fp = 0; e_sh = 0; e_de = 0; e_c2 = 0; e_ctl = '0; e_pix = '0;
         load_shadow();
      end else begin
         bit hd, vd, tft, flast;
         hd = (m_hc >= s_hs) && (m_hc < s_hs + s_hl);
         vd = (m_vc >= s_vs) && (m_vc < s_vs + s_vl);
         tft = (s_mode >= 2);
         e_lp = (m_hc >= s_hps) && (m_hc < s_hps + s_hpw);
         e_de = hd && vd;
         e_pix = e_de ? pix_in : '0;
         if (s_mode == 0) e_sh = s_mask ? hd : 1'b1;
         else             e_sh = hd;
         if (m_vc == s_vps && m_hc == s_hps + s_fon) e_fp = 1'b1;
         else if (m_vc == s_vps + s_vpw && m_hc == s_hps + s_foff) e_fp = 1'b0;
         if (!tft) e_c2 = 1'b0;
         else if (m_hc == s_c2d) e_c2 = !e_c2;
         e_ctl[0] = tft && m_hc >= s_c0a && m_hc < s_c0b;
         e_ctl[1] = tft && m_hc >= s_c1a && m_hc < s_c1b;
         e_ctl[2] = e_c2;
         e_ctl[3] = tft && m_hc == s_hs;
         flast = (m_hc + 1 >= s_ht) && (m_vc + 1 >= s_vt);
         if (m_hc + 1 >= s_ht) begin
            m_hc = 0;
            m_vc = (m_vc + 1 >= s_vt) ? 0 : m_vc + 1;
         end else m_hc = m_hc + 1;
         if (flast) load_shadow();
      end
   end

   task automatic chk(string req, string name, logic [31:0] act, logic [31:0] exp);
      string tag;
      tag = was_rst ? "R10" : (pend ? {req, "/R11"} : req);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h (line %0d pos %0d)",
                  tag, name, act, exp, m_vc, m_hc);
      end
   endtask

   always @(negedge clk) begin
      if (checking) begin
         chk("R1", "line_pulse", 32'(line_pulse), 32'(e_lp));
         chk("R2", "frame_pulse", 32'(frame_pulse), 32'(e_fp));
         chk("R3", "data_en", 32'(data_en), 32'(e_de));
         chk("R3", "pix_out", 32'(pix_out), 32'(e_pix));
         chk(s_mode == 0 ? "R5" : "R4", "shift_en", 32'(shift_en), 32'(e_sh));
         chk(s_mode >= 2 ? "R6" : "R9", "tft_ctl0_1", 32'(tft_ctl[1:0]), 32'(e_ctl[1:0]));
         chk(s_mode >= 2 ? "R7" : "R9", "tft_ctl2", 32'(tft_ctl[2]), 32'(e_ctl[2]));
         chk(s_mode >= 2 ? "R8" : "R9", "tft_ctl3", 32'(tft_ctl[3]), 32'(e_ctl[3]));
      end
   end

   always @(negedge clk) pix_in <= pix_in * 24'd5 + 24'h3c1a7;

   task automatic geom_a();
      h_total = 12; h_act_start = 3; h_act_len = 6; h_sync_start = 0; h_sync_len = 2;
      v_total = 6; v_act_start = 1; v_act_len = 3; v_sync_start = 0; v_sync_len = 1;
      fsync_on_ofs = 1; fsync_off_ofs = 3;
      ctl0_start = 0; ctl0_stop = 0; ctl1_start = 0; ctl1_stop = 0; ctl2_delay = 0;
   endtask

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      geom_a();
      @(negedge clk);
      checking = 1'b1;                 // R10: reset state checked here
      cycles(3);
      rst = 1'b0;
      cycles(150);                     // R5: mono, free-running shift
      mono_shift_mask = 1'b1; pend = 1'b1;
      cycles(150);                     // R5: mono, gated
      mode = 2'b01; pend = 1'b1;
      cycles(150);                     // R4: colour passive
      mode = 2'b10; pend = 1'b1;
      ctl0_start = 2; ctl0_stop = 5; ctl1_start = 6; ctl1_stop = 11; ctl2_delay = 4;
      cycles(150);                     // R6 R7 R8 in TFT mode
      cycles(37);
      // R11: geometry change part way through a frame
      h_total = 9; h_act_start = 5; h_act_len = 4; h_sync_start = 7; h_sync_len = 2;
      v_total = 5; v_act_start = 0; v_act_len = 5; v_sync_start = 3; v_sync_len = 1;
      fsync_on_ofs = 1; fsync_off_ofs = 0;
      ctl0_start = 0; ctl0_stop = 9; ctl1_start = 4; ctl1_stop = 4; ctl2_delay = 8;
      pend = 1'b1;
      cycles(160);
      rst = 1'b1;                      // R10: reset in the middle of TFT operation
      cycles(2);
      rst = 1'b0;
      cycles(60);
      mode = 2'b00; mono_shift_mask = 1'b0; pend = 1'b1;
      cycles(100);                     // R9 after leaving TFT mode
      checking = 1'b0;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule